// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block keeps the control state of a small 32-bit core with banked general registers: the program counter and the next program counter, the vector base, the status register, the three save registers that hold the context at entry (saved PC, saved status, saved R15) and the floating-point status word. It also holds the sixteen general registers. R0 to R7 are duplicated in a shadow bank, and the visible copy is exchanged with the shadow copy whenever the bank-select bit of the status register changes value.

The controller accepts four kinds of entry: general exceptions, TLB-miss exceptions, traps with an 8-bit immediate, and external interrupts. An accepted entry saves the context, records the event code in the exception event register or the interrupt event register, forces privileged, blocked and bank-1 mode, and moves the PC to the vector. All of this happens in one clock. A request to enter a low-power state goes to sleep or standby depending on a bit of the standby control register, and an accepted interrupt wakes the core. If an exception is raised while the vector base is still zero, the core halts and stays halted until reset.

Top module: `exc_entry_ctrl`

## Requirements
- R1: A synchronous active-low reset gives PC 0xA0000000, next PC 0xA0000002, vector base 0, status 0x700000F0, FP status 0x00040001 and exception event code 0. The run state becomes running (run_state encoding: 0 running, 1 sleep, 2 standby, 3 halted), the delay-slot flag is clear and every general register reads 0.
- R2: A taken general exception or trap sets PC to vector base + 0x100. A TLB-miss exception (exc_kind 1; 0 is general, 2 is trap) sets it to vector base + 0x400, and an interrupt sets it to vector base + 0x600. In all cases the next PC becomes the new PC + 2.
- R3: On any taken entry, the saved PC takes the current PC, the saved status takes the full status value with the flags T (bit 0), S (bit 1), Q (bit 8) and M (bit 9) included, and the saved R15 takes R15.
- R4: On a taken entry the status register becomes its old value with MD (bit 30), BL (bit 28) and RB (bit 29) set. If RB was 0, R0 to R7 are exchanged with the shadow bank in the same clock.
- R5: A status write whose RB bit differs from the current RB exchanges R0 to R7 with the shadow bank in one step. R8 to R15 are not affected, and a general-register write in the same cycle lands in the bank that is visible afterwards.
- R6: An exception taken while the delay-slot flag is set saves PC - 2 as the saved PC. Every taken exception clears the delay-slot flag.
- R7: A trap (exc_kind 2) writes its immediate shifted left by 2 into the trap register and records event code 0x160 in the exception event register.
- R8: For a general or TLB exception with exc_slot_sens high, the event code is exc_code_slot when the delay-slot flag is set and exc_code_norm otherwise. With exc_slot_sens low, exc_code_norm is always used.
- R9: An interrupt writes its code into the interrupt event register and leaves the exception event register unchanged. It is accepted only when BL is 0 and the delay-slot flag is clear.
- R10: An exception raised while the vector base is 0 halts the core. It does not vector and takes no entry, and in the halted state every request and write is ignored until reset.
- R11: A sleep request while running enters standby (state 2) when bit 7 of the standby control byte is 1, and sleep (state 1) otherwise. Out of the running state, steps, jumps and exceptions are ignored, and an accepted interrupt returns the core to running.
- R12: An exception takes priority over an interrupt in the same cycle. In a cycle where an entry is taken, all register writes are ignored. `taken` is high for exactly the one cycle after each accepted entry.
- R13: While running, a step moves PC to the next PC and advances the next PC by 2, clearing the delay-slot flag. A jump moves PC to the next PC, loads the next PC with the target and sets the delay-slot flag. A jump wins over a step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Sequential advance of PC |
| jmp_valid | input | 1 | Delayed jump request |
| jmp_target | input | 32 | Jump target |
| sr_wr | input | 1 | Status register write |
| sr_wdata | input | 32 | Status write value |
| flag_wr | input | 1 | Write of T, S, M, Q flags |
| flag_t | input | 1 | T flag value |
| flag_s | input | 1 | S flag value |
| flag_m | input | 1 | M flag value |
| flag_q | input | 1 | Q flag value |
| vbr_wr | input | 1 | Vector base write |
| vbr_wdata | input | 32 | Vector base value |
| fpscr_wr | input | 1 | FP status write |
| fpscr_wdata | input | 32 | FP status value |
| stbcr_wr | input | 1 | Standby control write |
| stbcr_wdata | input | 8 | Standby control value |
| gpr_wr | input | 1 | General register write |
| gpr_widx | input | 4 | Write index |
| gpr_wdata | input | 32 | Write data |
| gpr_ridx | input | 4 | Read index |
| gpr_rdata | output | 32 | Read data (visible bank) |
| exc_req | input | 1 | Exception request |
| exc_kind | input | 2 | 0 general, 1 TLB miss, 2 trap |
| exc_code_norm | input | 12 | Code outside a delay slot |
| exc_code_slot | input | 12 | Code inside a delay slot |
| exc_slot_sens | input | 1 | Request is slot-sensitive |
| trap_imm | input | 8 | Trap immediate |
| irq_req | input | 1 | External interrupt request |
| irq_code | input | 12 | Accepted interrupt code |
| sleep_req | input | 1 | Low-power request |
| pc_q | output | 32 | Program counter |
| npc_q | output | 32 | Next program counter |
| vbr_q | output | 32 | Vector base |
| sr_q | output | 32 | Status register with flags |
| spc_q | output | 32 | Saved PC |
| ssr_q | output | 32 | Saved status |
| sgr_q | output | 32 | Saved R15 |
| fpscr_q | output | 32 | FP status |
| expevt_q | output | 12 | Exception event code |
| intevt_q | output | 12 | Interrupt event code |
| tra_q | output | 32 | Trap register |
| in_slot_q | output | 1 | Delay-slot flag |
| run_state | output | 2 | Run state |
| taken | output | 1 | Entry accepted last cycle |

## Verification
The hardest situation to reach is an exception inside a delay slot. Getting there needs a jump to set the delay-slot flag, an interrupt that must be refused in that same slot, and then a slot-sensitive exception. Only that sequence exercises the PC - 2 correction and the slot-code choice together. The stimulus first drops BL and RB with a status write, issues a jump, presents an interrupt in the slot, and only then raises the exception. Bank exchanges are made visible by writing different values into both banks through alternating status writes and reading R3 after each exchange.

// File: rtl/exc_entry_pkg.sv
// Shared constants and types for the exception entry controller.
// Assumes a 32-bit status word with fixed flag and mode bit positions.
package exc_entry_pkg;
    localparam int SR_T  = 0;
    localparam int SR_S  = 1;
    localparam int SR_Q  = 8;
    localparam int SR_M  = 9;
    localparam int SR_BL = 28;
    localparam int SR_RB = 29;
    localparam int SR_MD = 30;

    localparam logic [31:0] VEC_GENERAL = 32'h0000_0100;
    localparam logic [31:0] VEC_TLB     = 32'h0000_0400;
    localparam logic [31:0] VEC_IRQ     = 32'h0000_0600;

    typedef enum logic [1:0] {
        RS_RUN     = 2'd0,
        RS_SLEEP   = 2'd1,
        RS_STANDBY = 2'd2,
        RS_HALT    = 2'd3
    } run_state_e;

    typedef enum logic [1:0] {
        EK_GENERAL = 2'd0,
        EK_TLB     = 2'd1,
        EK_TRAP    = 2'd2
    } exc_kind_e;
endpackage

// File: rtl/exc_gpr_bank.sv
// General register file with a shadow copy of the low registers.
// The visible low registers are exchanged with the shadow copy when
// swap is high; a write in the same cycle lands after the exchange.
// Assumes NBANKED < NGPR and both are powers of two.
module exc_gpr_bank #(
    parameter int XLEN    = 32,
    parameter int NGPR    = 16,
    parameter int NBANKED = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    swap,
    input  logic                    wr_en,
    input  logic [$clog2(NGPR)-1:0] wr_idx,
    input  logic [XLEN-1:0]         wr_data,
    input  logic [$clog2(NGPR)-1:0] rd_idx,
    output logic [XLEN-1:0]         rd_data,
    output logic [XLEN-1:0]         top_reg
);
    localparam int IDX_W  = $clog2(NGPR);
    localparam int NUPPER = NGPR - NBANKED;
    localparam int BIDX_W = $clog2(NBANKED);
    localparam int UIDX_W = $clog2(NUPPER);

    logic [XLEN-1:0] front  [NBANKED];
    logic [XLEN-1:0] shadow [NBANKED];
    logic [XLEN-1:0] upper  [NUPPER];
    logic [IDX_W-1:0] rd_uoff;

    genvar g;
    generate
        for (g = 0; g < NBANKED; g++) begin : g_banked
            // Exchange with shadow on swap, then apply a write to the visible copy.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    front[g]  <= '0;
                    shadow[g] <= '0;
                end else begin
                    if (swap) begin
                        front[g]  <= shadow[g];
                        shadow[g] <= front[g];
                    end
                    if (wr_en && wr_idx == IDX_W'(g))
                        front[g] <= wr_data;
                end
            end
        end
        for (g = 0; g < NUPPER; g++) begin : g_upper
            // Unbanked registers take writes only.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    upper[g] <= '0;
                else if (wr_en && wr_idx == IDX_W'(g + NBANKED))
                    upper[g] <= wr_data;
            end
        end
    endgenerate

    // Read mux over the visible bank and the unbanked registers.
    always_comb begin
        rd_uoff = rd_idx - IDX_W'(NBANKED);
        if (rd_idx < IDX_W'(NBANKED))
            rd_data = front[rd_idx[BIDX_W-1:0]];
        else
            rd_data = upper[rd_uoff[UIDX_W-1:0]];
    end

    assign top_reg = upper[NUPPER-1];
endmodule

// File: rtl/exc_sr_unit.sv
// Status register with separately held T, S, M, Q flags.
// Produces the merged status value and the bank-swap strobe whenever the
// bank-select bit is about to change. An entry forces MD, BL and RB.
// Assumes the caller gates wr_en and flag_wr off in entry cycles.
module exc_sr_unit
    import exc_entry_pkg::*;
#(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  RESET_SR = 32'h7000_00F0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            entry,
    input  logic            wr_en,
    input  logic [XLEN-1:0] wr_data,
    input  logic            flag_wr,
    input  logic            flag_t,
    input  logic            flag_s,
    input  logic            flag_m,
    input  logic            flag_q,
    output logic [XLEN-1:0] sr_out,
    output logic            swap
);
    localparam logic [XLEN-1:0] FLAG_MASK =
        (XLEN'(1) << SR_T) | (XLEN'(1) << SR_S) | (XLEN'(1) << SR_Q) | (XLEN'(1) << SR_M);
    localparam logic [XLEN-1:0] ENTRY_SET =
        (XLEN'(1) << SR_MD) | (XLEN'(1) << SR_BL) | (XLEN'(1) << SR_RB);

    logic [XLEN-1:0] body;
    logic            ft, fs, fm, fq;
    logic            next_rb;
    logic [XLEN-1:0] flag_bits;

    // Merge the flag bits into the stored body.
    always_comb begin
        flag_bits        = '0;
        flag_bits[SR_T]  = ft;
        flag_bits[SR_S]  = fs;
        flag_bits[SR_Q]  = fq;
        flag_bits[SR_M]  = fm;
        sr_out           = body | flag_bits;
    end

    // Work out the bank bit after this cycle and whether it changes.
    always_comb begin
        if (entry)
            next_rb = 1'b1;
        else if (wr_en)
            next_rb = wr_data[SR_RB];
        else
            next_rb = body[SR_RB];
        swap = (next_rb != body[SR_RB]);
    end

    // Status body and flag update: entry, then full write, then flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            body <= RESET_SR & ~FLAG_MASK;
            ft   <= RESET_SR[SR_T];
            fs   <= RESET_SR[SR_S];
            fm   <= RESET_SR[SR_M];
            fq   <= RESET_SR[SR_Q];
        end else if (entry) begin
            body <= body | ENTRY_SET;
        end else if (wr_en) begin
            body <= wr_data & ~FLAG_MASK;
            ft   <= wr_data[SR_T];
            fs   <= wr_data[SR_S];
            fm   <= wr_data[SR_M];
            fq   <= wr_data[SR_Q];
        end else if (flag_wr) begin
            ft <= flag_t;
            fs <= flag_s;
            fm <= flag_m;
            fq <= flag_q;
        end
    end
endmodule

// File: rtl/exc_entry_arb.sv
// Combinational entry arbiter. Decides in the current cycle whether an
// exception, a halt or an interrupt is taken, and computes the vector,
// the event code and the saved PC. Exceptions win over interrupts.
// Assumes run state, slot flag and status are registered elsewhere.
module exc_entry_arb
    import exc_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              CODE_W    = 12,
    parameter logic [CODE_W-1:0] TRAP_CODE = 12'h160
) (
    input  logic              exc_req,
    input  logic [1:0]        exc_kind,
    input  logic [CODE_W-1:0] exc_code_norm,
    input  logic [CODE_W-1:0] exc_code_slot,
    input  logic              exc_slot_sens,
    input  logic              irq_req,
    input  logic [1:0]        state,
    input  logic              in_slot,
    input  logic              sr_bl,
    input  logic [XLEN-1:0]   vbr,
    input  logic [XLEN-1:0]   pc,
    output logic              exc_att,
    output logic              do_exc,
    output logic              do_halt,
    output logic              do_irq,
    output logic              is_trap,
    output logic [CODE_W-1:0] exc_code,
    output logic [XLEN-1:0]   vec_pc,
    output logic [XLEN-1:0]   save_pc
);
    logic vbr_zero;

    // Acceptance decisions in priority order.
    always_comb begin
        vbr_zero = (vbr == '0);
        exc_att  = exc_req && (state == RS_RUN);
        do_halt  = exc_att && vbr_zero;
        do_exc   = exc_att && !vbr_zero;
        do_irq   = !exc_att && irq_req && !sr_bl && !in_slot && (state != RS_HALT);
        is_trap  = (exc_kind == EK_TRAP);
    end

    // Event code selection for exceptions.
    always_comb begin
        if (is_trap)
            exc_code = TRAP_CODE;
        else if (exc_slot_sens && in_slot)
            exc_code = exc_code_slot;
        else
            exc_code = exc_code_norm;
    end

    // Vector target and the PC value to save.
    always_comb begin
        if (do_irq)
            vec_pc = vbr + VEC_IRQ;
        else if (exc_kind == EK_TLB)
            vec_pc = vbr + VEC_TLB;
        else
            vec_pc = vbr + VEC_GENERAL;
        save_pc = (do_exc && in_slot) ? pc - XLEN'(2) : pc;
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
// Exception entry controller: holds PC, next PC, vector base, status,
// save registers, event registers, trap register and run state, and
// performs a one-clock entry on exceptions, traps and interrupts.
// Assumes requests are held by the requester until seen; entries are
// single-cycle so no request is pended here.
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int                XLEN       = 32,
    parameter int                CODE_W     = 12,
    parameter int                IMM_W      = 8,
    parameter int                NGPR       = 16,
    parameter int                NBANKED    = 8,
    parameter int                STB_W      = 8,
    parameter int                STB_BIT    = 7,
    parameter logic [XLEN-1:0]   RESET_PC   = 32'hA000_0000,
    parameter logic [XLEN-1:0]   RESET_SR   = 32'h7000_00F0,
    parameter logic [XLEN-1:0]   RESET_FPS  = 32'h0004_0001,
    parameter logic [CODE_W-1:0] RESET_CODE = 12'h000,
    parameter logic [CODE_W-1:0] TRAP_CODE  = 12'h160
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    jmp_valid,
    input  logic [XLEN-1:0]         jmp_target,
    input  logic                    sr_wr,
    input  logic [XLEN-1:0]         sr_wdata,
    input  logic                    flag_wr,
    input  logic                    flag_t,
    input  logic                    flag_s,
    input  logic                    flag_m,
    input  logic                    flag_q,
    input  logic                    vbr_wr,
    input  logic [XLEN-1:0]         vbr_wdata,
    input  logic                    fpscr_wr,
    input  logic [XLEN-1:0]         fpscr_wdata,
    input  logic                    stbcr_wr,
    input  logic [STB_W-1:0]        stbcr_wdata,
    input  logic                    gpr_wr,
    input  logic [$clog2(NGPR)-1:0] gpr_widx,
    input  logic [XLEN-1:0]         gpr_wdata,
    input  logic [$clog2(NGPR)-1:0] gpr_ridx,
    output logic [XLEN-1:0]         gpr_rdata,
    input  logic                    exc_req,
    input  logic [1:0]              exc_kind,
    input  logic [CODE_W-1:0]       exc_code_norm,
    input  logic [CODE_W-1:0]       exc_code_slot,
    input  logic                    exc_slot_sens,
    input  logic [IMM_W-1:0]        trap_imm,
    input  logic                    irq_req,
    input  logic [CODE_W-1:0]       irq_code,
    input  logic                    sleep_req,
    output logic [XLEN-1:0]         pc_q,
    output logic [XLEN-1:0]         npc_q,
    output logic [XLEN-1:0]         vbr_q,
    output logic [XLEN-1:0]         sr_q,
    output logic [XLEN-1:0]         spc_q,
    output logic [XLEN-1:0]         ssr_q,
    output logic [XLEN-1:0]         sgr_q,
    output logic [XLEN-1:0]         fpscr_q,
    output logic [CODE_W-1:0]       expevt_q,
    output logic [CODE_W-1:0]       intevt_q,
    output logic [XLEN-1:0]         tra_q,
    output logic                    in_slot_q,
    output logic [1:0]              run_state,
    output logic                    taken
);
    localparam int TRA_PAD = XLEN - IMM_W - 2;

    run_state_e        state;
    logic [STB_W-1:0]  stbcr;
    logic              exc_att, do_exc, do_halt, do_irq, is_trap;
    logic [CODE_W-1:0] exc_code;
    logic [XLEN-1:0]   vec_pc, save_pc;
    logic              entry, wr_ok, running, bank_swap;
    logic [XLEN-1:0]   r15;

    exc_entry_arb #(
        .XLEN(XLEN), .CODE_W(CODE_W), .TRAP_CODE(TRAP_CODE)
    ) u_arb (
        .exc_req       (exc_req),
        .exc_kind      (exc_kind),
        .exc_code_norm (exc_code_norm),
        .exc_code_slot (exc_code_slot),
        .exc_slot_sens (exc_slot_sens),
        .irq_req       (irq_req),
        .state         (state),
        .in_slot       (in_slot_q),
        .sr_bl         (sr_q[SR_BL]),
        .vbr           (vbr_q),
        .pc            (pc_q),
        .exc_att       (exc_att),
        .do_exc        (do_exc),
        .do_halt       (do_halt),
        .do_irq        (do_irq),
        .is_trap       (is_trap),
        .exc_code      (exc_code),
        .vec_pc        (vec_pc),
        .save_pc       (save_pc)
    );

    // Cycle qualifiers: entry taken, ordinary writes allowed, core running.
    always_comb begin
        entry   = do_exc || do_irq;
        wr_ok   = !exc_att && !do_irq && (state != RS_HALT);
        running = (state == RS_RUN);
    end

    exc_sr_unit #(
        .XLEN(XLEN), .RESET_SR(RESET_SR)
    ) u_sr (
        .clk     (clk),
        .rst_n   (rst_n),
        .entry   (entry),
        .wr_en   (sr_wr && wr_ok),
        .wr_data (sr_wdata),
        .flag_wr (flag_wr && wr_ok),
        .flag_t  (flag_t),
        .flag_s  (flag_s),
        .flag_m  (flag_m),
        .flag_q  (flag_q),
        .sr_out  (sr_q),
        .swap    (bank_swap)
    );

    exc_gpr_bank #(
        .XLEN(XLEN), .NGPR(NGPR), .NBANKED(NBANKED)
    ) u_gpr (
        .clk     (clk),
        .rst_n   (rst_n),
        .swap    (bank_swap),
        .wr_en   (gpr_wr && wr_ok),
        .wr_idx  (gpr_widx),
        .wr_data (gpr_wdata),
        .rd_idx  (gpr_ridx),
        .rd_data (gpr_rdata),
        .top_reg (r15)
    );

    // Program flow and context save.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q      <= RESET_PC;
            npc_q     <= RESET_PC + XLEN'(2);
            in_slot_q <= 1'b0;
            spc_q     <= '0;
            ssr_q     <= '0;
            sgr_q     <= '0;
        end else if (entry) begin
            spc_q <= save_pc;
            ssr_q <= sr_q;
            sgr_q <= r15;
            pc_q  <= vec_pc;
            npc_q <= vec_pc + XLEN'(2);
            if (do_exc)
                in_slot_q <= 1'b0;
        end else if (wr_ok && running) begin
            if (jmp_valid) begin
                pc_q      <= npc_q;
                npc_q     <= jmp_target;
                in_slot_q <= 1'b1;
            end else if (step) begin
                pc_q      <= npc_q;
                npc_q     <= npc_q + XLEN'(2);
                in_slot_q <= 1'b0;
            end
        end
    end

    // Event code and trap registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expevt_q <= RESET_CODE;
            intevt_q <= '0;
            tra_q    <= '0;
        end else begin
            if (do_exc)
                expevt_q <= exc_code;
            if (do_irq)
                intevt_q <= irq_code;
            if (exc_att && is_trap)
                tra_q <= {{TRA_PAD{1'b0}}, trap_imm, 2'b00};
        end
    end

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vbr_q   <= '0;
            fpscr_q <= RESET_FPS;
            stbcr   <= '0;
        end else if (wr_ok) begin
            if (vbr_wr)
                vbr_q <= vbr_wdata;
            if (fpscr_wr)
                fpscr_q <= fpscr_wdata;
            if (stbcr_wr)
                stbcr <= stbcr_wdata;
        end
    end

    // Run state: halt on a failed exception, wake on interrupt, low-power on request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= RS_RUN;
        else if (do_halt)
            state <= RS_HALT;
        else if (do_irq)
            state <= RS_RUN;
        else if (wr_ok && running && sleep_req)
            state <= stbcr[STB_BIT] ? RS_STANDBY : RS_SLEEP;
    end

    // One-cycle pulse after each accepted entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            taken <= 1'b0;
        else
            taken <= entry;
    end

    assign run_state = state;
endmodule

// File: rtl/exc_entry_chk.sv
// Property checker for the exception entry controller, bound to the top.
// Assumes the top's default widths for status bit positions.
module exc_entry_chk
    import exc_entry_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_q,
    input logic [31:0] npc_q,
    input logic [31:0] vbr_q,
    input logic [31:0] sr_q,
    input logic        in_slot_q,
    input logic [1:0]  run_state,
    input logic        taken,
    input logic        irq_req,
    input logic        exc_req
);
    AST_ENTRY_NPC: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (npc_q == pc_q + 32'd2)); // R2

    AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ((pc_q - vbr_q == VEC_GENERAL) || (pc_q - vbr_q == VEC_TLB) ||
                   (pc_q - vbr_q == VEC_IRQ))); // R2

    AST_ENTRY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (sr_q[SR_MD] && sr_q[SR_BL] && sr_q[SR_RB])); // R4

    AST_ENTRY_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> !in_slot_q); // R6

    AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !exc_req && (sr_q[SR_BL] || in_slot_q)) |=> !taken); // R9

    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (run_state == RS_HALT) |=> ((run_state == RS_HALT) && $stable(pc_q) && !taken)); // R10

    AST_TAKEN_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> (run_state == RS_RUN)); // R11
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pc_q      (pc_q),
    .npc_q     (npc_q),
    .vbr_q     (vbr_q),
    .sr_q      (sr_q),
    .in_slot_q (in_slot_q),
    .run_state (run_state),
    .taken     (taken),
    .irq_req   (irq_req),
    .exc_req   (exc_req)
);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 0, jmp_valid = 0, sr_wr = 0, flag_wr = 0;
    logic        flag_t = 0, flag_s = 0, flag_m = 0, flag_q = 0;
    logic        vbr_wr = 0, fpscr_wr = 0, stbcr_wr = 0, gpr_wr = 0;
    logic [31:0] jmp_target = 0, sr_wdata = 0, vbr_wdata = 0, fpscr_wdata = 0, gpr_wdata = 0;
    logic [7:0]  stbcr_wdata = 0, trap_imm = 0;
    logic [3:0]  gpr_widx = 0, gpr_ridx = 0;
    logic        exc_req = 0, exc_slot_sens = 0, irq_req = 0, sleep_req = 0;
    logic [1:0]  exc_kind = 0;
    logic [11:0] exc_code_norm = 0, exc_code_slot = 0, irq_code = 0;

    logic [31:0] gpr_rdata, pc_q, npc_q, vbr_q, sr_q, spc_q, ssr_q, sgr_q, fpscr_q, tra_q;
    logic [11:0] expevt_q, intevt_q;
    logic        in_slot_q, taken;
    logic [1:0]  run_state;

    exc_entry_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // Behavioural reference model: banks indexed by RB instead of swapped.
    logic [31:0] m_pc, m_npc, m_vbr, m_sr, m_spc, m_ssr, m_sgr, m_fps, m_tra;
    logic [31:0] m_exp, m_int;
    logic [7:0]  m_stb;
    logic [1:0]  m_state;
    logic        m_slot, m_taken, m_ea, m_ia, m_run;
    logic [31:0] mb0 [8];
    logic [31:0] mb1 [8];
    logic [31:0] mhi [8];

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pc = 32'hA000_0000; m_npc = 32'hA000_0002; m_vbr = 0; m_sr = 32'h7000_00F0;
            m_spc = 0; m_ssr = 0; m_sgr = 0; m_fps = 32'h0004_0001; m_tra = 0;
            m_exp = 0; m_int = 0; m_stb = 0; m_state = 0; m_slot = 0; m_taken = 0;
            for (int i = 0; i < 8; i++) begin mb0[i] = 0; mb1[i] = 0; mhi[i] = 0; end
        end else begin
            m_ea = exc_req && (m_state == 0);
            m_ia = !m_ea && irq_req && !m_sr[28] && !m_slot && (m_state != 3);
            m_run = (m_state == 0);
            m_taken = 0;
            if (m_ea && exc_kind == 2) m_tra = {22'd0, trap_imm, 2'b00};
            if (m_ea && m_vbr == 0) begin
                m_state = 3;
            end else if (m_ea) begin
                if (exc_kind == 2) m_exp = 32'h160;
                else if (exc_slot_sens && m_slot) m_exp = {20'd0, exc_code_slot};
                else m_exp = {20'd0, exc_code_norm};
                m_spc = m_slot ? m_pc - 2 : m_pc;
                m_ssr = m_sr; m_sgr = mhi[7];
                m_pc = m_vbr + ((exc_kind == 1) ? 32'h400 : 32'h100);
                m_npc = m_pc + 2; m_sr = m_sr | 32'h7000_0000; m_slot = 0; m_taken = 1;
            end else if (m_ia) begin
                m_int = {20'd0, irq_code};
                m_spc = m_pc; m_ssr = m_sr; m_sgr = mhi[7];
                m_pc = m_vbr + 32'h600; m_npc = m_pc + 2;
                m_sr = m_sr | 32'h7000_0000; m_state = 0; m_taken = 1;
            end else if (m_state != 3) begin
                if (m_run && sleep_req) m_state = m_stb[7] ? 2 : 1;
                if (m_run && jmp_valid) begin
                    m_pc = m_npc; m_npc = jmp_target; m_slot = 1;
                end else if (m_run && step) begin
                    m_pc = m_npc; m_npc = m_npc + 2; m_slot = 0;
                end
                if (sr_wr) m_sr = sr_wdata;
                else if (flag_wr)
                    m_sr = (m_sr & ~32'h303) | {22'd0, flag_m, flag_q, 6'd0, flag_s, flag_t};
                if (vbr_wr) m_vbr = vbr_wdata;
                if (fpscr_wr) m_fps = fpscr_wdata;
                if (stbcr_wr) m_stb = stbcr_wdata;
                if (gpr_wr) begin
                    if (gpr_widx < 8) begin
                        if (m_sr[29]) mb1[gpr_widx[2:0]] = gpr_wdata;
                        else mb0[gpr_widx[2:0]] = gpr_wdata;
                    end else mhi[gpr_widx[2:0]] = gpr_wdata;
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [3:0] idx);
        if (idx >= 8) return mhi[idx[2:0]];
        return m_sr[29] ? mb1[idx[2:0]] : mb0[idx[2:0]];
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R13 pc model", pc_q, m_pc);
        chk("R13 npc model", npc_q, m_npc);
        chk("R1 vbr model", vbr_q, m_vbr);
        chk("R4 sr model", sr_q, m_sr);
        chk("R3 spc model", spc_q, m_spc);
        chk("R3 ssr model", ssr_q, m_ssr);
        chk("R3 sgr model", sgr_q, m_sgr);
        chk("R1 fpscr model", fpscr_q, m_fps);
        chk("R8 expevt model", {20'd0, expevt_q}, m_exp);
        chk("R9 intevt model", {20'd0, intevt_q}, m_int);
        chk("R7 tra model", tra_q, m_tra);
        chk("R6 slot model", {31'd0, in_slot_q}, {31'd0, m_slot});
        chk("R11 state model", {30'd0, run_state}, {30'd0, m_state});
        chk("R12 taken model", {31'd0, taken}, {31'd0, m_taken});
        chk("R5 gpr read model", gpr_rdata, m_read(gpr_ridx));
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        step = 0; jmp_valid = 0; sr_wr = 0; flag_wr = 0; vbr_wr = 0; fpscr_wr = 0;
        stbcr_wr = 0; gpr_wr = 0; exc_req = 0; exc_slot_sens = 0; irq_req = 0; sleep_req = 0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 0;
        repeat (3) tick();
        rst_n = 1;
    endtask

    task automatic raise(input logic [1:0] kind, input logic [11:0] cn, input logic [11:0] cs,
                         input logic sens);
        exc_req = 1; exc_kind = kind; exc_code_norm = cn; exc_code_slot = cs; exc_slot_sens = sens;
        tick(); idle();
    endtask

    task automatic write_sr(input logic [31:0] v);
        sr_wr = 1; sr_wdata = v; tick(); idle();
    endtask

    // Watchdog: counts as a failed check and still reports.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        do_reset();
        tick();
        chk("R1 reset pc", pc_q, 32'hA000_0000);
        chk("R1 reset npc", npc_q, 32'hA000_0002);
        chk("R1 reset sr", sr_q, 32'h7000_00F0);
        chk("R1 reset fpscr", fpscr_q, 32'h0004_0001);
        chk("R1 reset vbr", vbr_q, 32'h0);
        chk("R1 reset state", {30'd0, run_state}, 32'd0);

        // Exception with zero vector base halts.
        raise(2'd0, 12'h1E0, 12'h0, 1'b0);
        chk("R10 halted", {30'd0, run_state}, 32'd3);
        chk("R10 no vector", pc_q, 32'hA000_0000);
        step = 1; vbr_wr = 1; vbr_wdata = 32'h1234; tick(); idle();
        chk("R10 step ignored", pc_q, 32'hA000_0000);
        chk("R10 write ignored", vbr_q, 32'h0);
        do_reset();

        vbr_wr = 1; vbr_wdata = 32'h8C00_0000; tick(); idle();
        for (int i = 0; i < 16; i++) begin
            gpr_wr = 1; gpr_widx = 4'(i); gpr_wdata = 32'h100 + i; tick();
        end
        idle();
        gpr_ridx = 4'd3;
        write_sr(32'h0000_0000);
        chk("R5 bank0 visible", gpr_rdata, 32'h0);
        gpr_wr = 1; gpr_widx = 4'd3; gpr_wdata = 32'hB0B0; tick(); idle();
        write_sr(32'h2000_0000);
        chk("R5 bank1 back", gpr_rdata, 32'h103);
        write_sr(32'h0000_0000);
        chk("R5 bank0 kept", gpr_rdata, 32'hB0B0);
        gpr_ridx = 4'd12; tick();
        chk("R5 upper unbanked", gpr_rdata, 32'h10C);
        gpr_ridx = 4'd3;

        flag_wr = 1; flag_t = 1; flag_q = 1; tick(); idle();
        step = 1; tick(); tick(); idle();
        chk("R13 step pc", pc_q, 32'hA000_0004);
        chk("R13 step npc", npc_q, 32'hA000_0006);

        raise(2'd0, 12'h180, 12'h1A0, 1'b0);
        chk("R2 general vector", pc_q, 32'h8C00_0100);
        chk("R2 npc after entry", npc_q, 32'h8C00_0102);
        chk("R3 spc", spc_q, 32'hA000_0004);
        chk("R3 ssr flags merged", ssr_q, 32'h0000_0101);
        chk("R3 sgr", sgr_q, 32'h10F);
        chk("R4 forced sr", sr_q, 32'h7000_0101);
        chk("R4 entry bank swap", gpr_rdata, 32'h103);
        chk("R12 taken pulse", {31'd0, taken}, 32'd1);
        tick();
        chk("R12 taken one cycle", {31'd0, taken}, 32'd0);

        write_sr(32'h0);
        jmp_valid = 1; jmp_target = 32'h8C00_1000; tick(); idle();
        chk("R13 jump npc", npc_q, 32'h8C00_1000);
        chk("R13 slot set", {31'd0, in_slot_q}, 32'd1);
        irq_req = 1; irq_code = 12'h3C0; tick(); idle();
        chk("R9 irq refused in slot", {31'd0, taken}, 32'd0);
        raise(2'd0, 12'h180, 12'h1A0, 1'b1);
        chk("R8 slot code", {20'd0, expevt_q}, 32'h1A0);
        chk("R6 spc minus two", spc_q, 32'h8C00_0100);
        chk("R6 slot cleared", {31'd0, in_slot_q}, 32'd0);

        write_sr(32'h0);
        raise(2'd0, 12'h180, 12'h1A0, 1'b1);
        chk("R8 normal code", {20'd0, expevt_q}, 32'h180);

        write_sr(32'h0);
        trap_imm = 8'hA5;
        raise(2'd2, 12'h0, 12'h0, 1'b0);
        chk("R7 tra", tra_q, 32'h294);
        chk("R7 trap code", {20'd0, expevt_q}, 32'h160);
        chk("R7 trap vector", pc_q, 32'h8C00_0100);

        write_sr(32'h0);
        raise(2'd1, 12'h040, 12'h0, 1'b0);
        chk("R2 tlb vector", pc_q, 32'h8C00_0400);

        irq_req = 1; irq_code = 12'h320; tick(); idle();
        chk("R9 irq blocked by BL", {31'd0, taken}, 32'd0);
        write_sr(32'h0);
        irq_req = 1; irq_code = 12'h320; tick(); idle();
        chk("R9 intevt", {20'd0, intevt_q}, 32'h320);
        chk("R9 expevt kept", {20'd0, expevt_q}, 32'h040);
        chk("R2 irq vector", pc_q, 32'h8C00_0600);

        write_sr(32'h0);
        irq_req = 1; irq_code = 12'h3A0; vbr_wr = 1; vbr_wdata = 32'h0;
        raise(2'd0, 12'h1E0, 12'h0, 1'b0);
        chk("R12 exception wins", {20'd0, expevt_q}, 32'h1E0);
        chk("R12 intevt unchanged", {20'd0, intevt_q}, 32'h320);
        chk("R12 write ignored on entry", vbr_q, 32'h8C00_0000);

        write_sr(32'h0);
        stbcr_wr = 1; stbcr_wdata = 8'h00; tick(); idle();
        sleep_req = 1; tick(); idle();
        chk("R11 sleep", {30'd0, run_state}, 32'd1);
        step = 1; tick(); idle();
        chk("R11 step ignored", pc_q, 32'h8C00_0100);
        raise(2'd0, 12'h180, 12'h0, 1'b0);
        chk("R11 exception ignored", pc_q, 32'h8C00_0100);
        irq_req = 1; irq_code = 12'h300; tick(); idle();
        chk("R11 irq wakes", {30'd0, run_state}, 32'd0);
        chk("R11 wake vector", pc_q, 32'h8C00_0600);

        write_sr(32'h0);
        stbcr_wr = 1; stbcr_wdata = 8'h80; tick(); idle();
        sleep_req = 1; tick(); idle();
        chk("R11 standby", {30'd0, run_state}, 32'd2);
        tick();

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule